// File: doc/BRIEF.md
# Fuse-Driven Steering Target Selector

This block turns a snapshot of fuse and presence information into one safe steering target per class of replicated register. A target is a group/instance pair. A unicast access steered to that pair is guaranteed to reach a unit that exists and is powered, so it is never terminated. The block serves six classes:

- memory slice
- the cache-fabric slice half (LNCF)
- L3 bank
- node-replicated PSMI
- DSS
- media OA

Each class derives its target with its own rule. The rules are built on a lowest-set-bit search plus a small class-specific adjustment.

A one-cycle `start` pulse captures every input. The DSS index is then split into group and instance by a bit-serial divider. When the divider finishes, all targets are written at once and `done` pulses for one cycle. The targets then hold until the next completed run, so the lookup logic downstream can read them at any time. Classes whose instance is always zero (memory slice, LNCF, media OA) have only a group output.

Top module: `steer_target_sel`

## Requirements
- R1: After reset, every target output, `done`, `busy` and `cfg_err` are 0.
- R2: The memory-slice group equals the index of the lowest set bit of `slice_en`. The LNCF group equals that index shifted left by one.
- R3: With `l3_legacy` = 0, the L3 group equals the lowest enabled slice index. The L3 instance is 0 when `l3_bank0_en` = 1 and 2 when it is 0.
- R4: With `l3_legacy` = 1, the L3 group is 0 and the L3 instance is the index of the lowest clear bit of `l3_fuse`.
- R5: With n as the lowest set bit index of `node_en`, the node group is n >> 1 and the node instance is n & 1.
- R6: With d as the lowest set bit index of (`dss_geom` | `dss_comp`), the DSS group is d / P and the DSS instance is d % P, where P is the DSS-per-group divisor.
- R7: P equals `dpg_cfg` when `dpg_valid` = 1 and `dpg_cfg` is nonzero. Otherwise P is taken from `plat_mode`: 0 gives 6, 1 gives 4, 2 gives 8, and 3 gives 4.
- R8: The media OA group is 0 when `media_vid0` or `media_ven0` is 1, and 1 when both are 0.
- R9: A search over an all-zero mask yields index 0. `cfg_err` is 1 with the results when any of these holds: `slice_en`, `node_en` or the combined DSS mask is zero, or `l3_legacy` = 1 with `l3_fuse` all ones.
- R10: `busy` rises one cycle after an accepted `start`. `done` is a single-cycle pulse on the clock edge that comes log2(DSS_W) edges after the accepted start edge, and `busy` is low while `done` is high.
- R11: Inputs are captured at the accepted start edge. A `start` pulse or an input change while `busy` is high has no effect. Target outputs change only on the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a computation (ignored while busy) |
| plat_mode | input | 2 | Platform layout selecting the default divisor |
| l3_legacy | input | 1 | Use the legacy L3 fuse rule |
| slice_en | input | SLICE_W | Memory-slice enable mask |
| l3_bank0_en | input | 1 | L3 bank 0 present within a slice |
| l3_fuse | input | L3F_W | Legacy L3 disable fuses (1 = disabled) |
| node_en | input | NODE_W | Node enable mask |
| dss_geom | input | DSS_W | Geometry DSS enable mask |
| dss_comp | input | DSS_W | Compute DSS enable mask |
| dpg_valid | input | 1 | `dpg_cfg` is supplied |
| dpg_cfg | input | DIV_W | Configured DSS count per group |
| media_vid0 | input | 1 | First video engine present |
| media_ven0 | input | 1 | First video-enhance engine present |
| busy | output | 1 | Division in progress |
| done | output | 1 | Targets updated this cycle |
| cfg_err | output | 1 | A mask search found no usable bit |
| mslice_grp | output | TGT_W | Memory-slice group target |
| lncf_grp | output | TGT_W | LNCF group target |
| l3_grp | output | TGT_W | L3 bank group target |
| l3_inst | output | TGT_W | L3 bank instance target |
| node_grp | output | TGT_W | Node PSMI group target |
| node_inst | output | TGT_W | Node PSMI instance target |
| dss_grp | output | TGT_W | DSS group target |
| dss_inst | output | TGT_W | DSS instance target |
| oa_grp | output | TGT_W | Media OA group target |

## Verification
Some properties are checked on every cycle by assertions. These are the handshake shape (`done` one cycle wide and never with `busy`, `busy` following an accepted start), targets changing only on a `done` edge, the LNCF group being twice the slice group, and the range limits on the node instance, media OA group and non-legacy L3 instance. The arithmetic content of each target can only be shown by the bench's sweeps. Those sweeps cover:

- every slice and node mask
- every legacy fuse pattern
- every DSS position against every divisor
- each platform fallback

The bench also shows that inputs are held from the start edge, that a start pulse during a run is dropped, and that the run takes a fixed latency.

// File: rtl/steer_pkg.sv
// Shared definitions for the steering target selector.
// Assumes: plat_mode values outside the named set fall back to the wide layout.
package steer_pkg;

    typedef enum logic [1:0] {
        PM_GEN1 = 2'd0,
        PM_WIDE = 2'd1,
        PM_HPC  = 2'd2,
        PM_RSVD = 2'd3
    } plat_mode_e;

    // Default DSS-per-group count for a platform layout.
    function automatic int unsigned dflt_dpg(plat_mode_e m);
        case (m)
            PM_GEN1: return 6;
            PM_HPC:  return 8;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/steer_ffs.sv
// Lowest-set-bit finder.
// Returns the index of the lowest 1 in vec, or 0 with none=1 when vec is empty.
// Assumes: W >= 2.
module steer_ffs #(
    parameter int W = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          none
);
    // Scan from the top so that the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        none = ~|vec;
    end
endmodule

// File: rtl/steer_div.sv
// Bit-serial restoring divider that resolves one quotient bit per cycle.
// load starts a run; `last` flags the cycle whose edge produces the final
// quo_nxt / rem_nxt, so the caller can register them on that same edge.
// Assumes: divisor is nonzero, N_W >= 2, and load is only asserted when idle.
module steer_div #(
    parameter int N_W = 4,
    parameter int D_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [N_W-1:0] dividend,
    input  logic [D_W-1:0] divisor,
    output logic           busy,
    output logic           last,
    output logic [N_W-1:0] quo_nxt,
    output logic [D_W-1:0] rem_nxt
);
    localparam int CNT_W = $clog2(N_W + 1);

    logic [N_W-1:0]   quo_q;
    logic [D_W-1:0]   rem_q;
    logic [D_W-1:0]   div_q;
    logic [CNT_W-1:0] cnt_q;
    logic [D_W:0]     rem_sh;
    logic [D_W:0]     rem_full;
    logic             fits;

    // One restoring step: shift in the next dividend bit, subtract if it fits.
    always_comb begin
        rem_sh   = {rem_q, quo_q[N_W-1]};
        fits     = rem_sh >= {1'b0, div_q};
        rem_full = fits ? rem_sh - {1'b0, div_q} : rem_sh;
        rem_nxt  = rem_full[D_W-1:0];
        quo_nxt  = {quo_q[N_W-2:0], fits};
    end

    // Load operands or advance one step per cycle while counting down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            div_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            quo_q <= dividend;
            rem_q <= '0;
            div_q <= divisor;
            cnt_q <= CNT_W'(N_W);
        end else if (cnt_q != '0) begin
            quo_q <= quo_nxt;
            rem_q <= rem_nxt;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = cnt_q != '0;
    assign last = cnt_q == CNT_W'(1);
endmodule

// File: rtl/steer_target_sel.sv
// Steering target selector: from fuse and presence masks, computes a
// non-terminated group/instance target per replicated-register class.
// Capture happens on an accepted start; every target updates together when
// the DSS divider finishes, marked by a one-cycle done pulse.
// Assumes: DSS_W is a power of two >= 4, and dpg_cfg fits in DIV_W bits.
module steer_target_sel
    import steer_pkg::*;
#(
    parameter int SLICE_W = 4,
    parameter int NODE_W  = 8,
    parameter int DSS_W   = 16,
    parameter int L3F_W   = 8,
    parameter int DIV_W   = 4,
    parameter int TGT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         plat_mode,
    input  logic               l3_legacy,
    input  logic [SLICE_W-1:0] slice_en,
    input  logic               l3_bank0_en,
    input  logic [L3F_W-1:0]   l3_fuse,
    input  logic [NODE_W-1:0]  node_en,
    input  logic [DSS_W-1:0]   dss_geom,
    input  logic [DSS_W-1:0]   dss_comp,
    input  logic               dpg_valid,
    input  logic [DIV_W-1:0]   dpg_cfg,
    input  logic               media_vid0,
    input  logic               media_ven0,
    output logic               busy,
    output logic               done,
    output logic               cfg_err,
    output logic [TGT_W-1:0]   mslice_grp,
    output logic [TGT_W-1:0]   lncf_grp,
    output logic [TGT_W-1:0]   l3_grp,
    output logic [TGT_W-1:0]   l3_inst,
    output logic [TGT_W-1:0]   node_grp,
    output logic [TGT_W-1:0]   node_inst,
    output logic [TGT_W-1:0]   dss_grp,
    output logic [TGT_W-1:0]   dss_inst,
    output logic [TGT_W-1:0]   oa_grp
);
    localparam int SIDX_W = $clog2(SLICE_W);
    localparam int NIDX_W = $clog2(NODE_W);
    localparam int DIDX_W = $clog2(DSS_W);
    localparam int LIDX_W = $clog2(L3F_W);

    logic [SIDX_W-1:0] slice_idx;
    logic [NIDX_W-1:0] node_idx;
    logic [DIDX_W-1:0] dss_idx;
    logic [LIDX_W-1:0] l3z_idx;
    logic              slice_none, node_none, dss_none, l3z_none;
    logic [DSS_W-1:0]  dss_any;
    logic [L3F_W-1:0]  l3_fuse_inv;
    logic [DIV_W-1:0]  dpg_sel;
    logic              accept;

    logic [SIDX_W-1:0] slice_idx_q;
    logic [NIDX_W-1:0] node_idx_q;
    logic [LIDX_W-1:0] l3z_idx_q;
    logic              legacy_q, bank0_q, media_q, err_q;

    logic              div_busy, div_last;
    logic [DIDX_W-1:0] div_quo;
    logic [DIV_W-1:0]  div_rem;

    // Combine the two DSS masks and invert the legacy fuses (1 = usable bank).
    always_comb begin
        dss_any     = dss_geom | dss_comp;
        l3_fuse_inv = ~l3_fuse;
        accept      = start & ~div_busy;
        dpg_sel     = (dpg_valid && dpg_cfg != '0) ? dpg_cfg
                    : DIV_W'(dflt_dpg(plat_mode_e'(plat_mode)));
    end

    steer_ffs #(.W(SLICE_W)) u_ffs_slice (.vec(slice_en),    .idx(slice_idx), .none(slice_none));
    steer_ffs #(.W(NODE_W))  u_ffs_node  (.vec(node_en),     .idx(node_idx),  .none(node_none));
    steer_ffs #(.W(DSS_W))   u_ffs_dss   (.vec(dss_any),     .idx(dss_idx),   .none(dss_none));
    steer_ffs #(.W(L3F_W))   u_ffs_l3    (.vec(l3_fuse_inv), .idx(l3z_idx),   .none(l3z_none));

    steer_div #(.N_W(DIDX_W), .D_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .dividend (dss_idx),
        .divisor  (dpg_sel),
        .busy     (div_busy),
        .last     (div_last),
        .quo_nxt  (div_quo),
        .rem_nxt  (div_rem)
    );

    // Hold the non-DSS search results from the accepted start until completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slice_idx_q <= '0;
            node_idx_q  <= '0;
            l3z_idx_q   <= '0;
            legacy_q    <= 1'b0;
            bank0_q     <= 1'b0;
            media_q     <= 1'b0;
            err_q       <= 1'b0;
        end else if (accept) begin
            slice_idx_q <= slice_idx;
            node_idx_q  <= node_idx;
            l3z_idx_q   <= l3z_idx;
            legacy_q    <= l3_legacy;
            bank0_q     <= l3_bank0_en;
            media_q     <= media_vid0 | media_ven0;
            err_q       <= slice_none | node_none | dss_none | (l3_legacy & l3z_none);
        end
    end

    // Publish every target together on the final divider step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            cfg_err    <= 1'b0;
            mslice_grp <= '0;
            lncf_grp   <= '0;
            l3_grp     <= '0;
            l3_inst    <= '0;
            node_grp   <= '0;
            node_inst  <= '0;
            dss_grp    <= '0;
            dss_inst   <= '0;
            oa_grp     <= '0;
        end else begin
            done <= div_last;
            if (div_last) begin
                cfg_err    <= err_q;
                mslice_grp <= TGT_W'(slice_idx_q);
                lncf_grp   <= TGT_W'(slice_idx_q) << 1;
                l3_grp     <= legacy_q ? '0 : TGT_W'(slice_idx_q);
                l3_inst    <= legacy_q ? TGT_W'(l3z_idx_q)
                                       : (bank0_q ? TGT_W'(0) : TGT_W'(2));
                node_grp   <= TGT_W'(node_idx_q >> 1);
                node_inst  <= TGT_W'(node_idx_q[0]);
                dss_grp    <= TGT_W'(div_quo);
                dss_inst   <= TGT_W'(div_rem);
                oa_grp     <= media_q ? TGT_W'(0) : TGT_W'(1);
            end
        end
    end

    assign busy = div_busy;
endmodule

// File: rtl/steer_target_sel_chk.sv
// Cycle-level protocol and range checks for steer_target_sel.
// Assumes: attached through the bind below; observes ports only.
module steer_target_sel_chk #(
    parameter int TGT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [TGT_W-1:0] mslice_grp,
    input logic [TGT_W-1:0] lncf_grp,
    input logic [TGT_W-1:0] l3_grp,
    input logic [TGT_W-1:0] l3_inst,
    input logic [TGT_W-1:0] node_grp,
    input logic [TGT_W-1:0] node_inst,
    input logic [TGT_W-1:0] dss_grp,
    input logic [TGT_W-1:0] dss_inst,
    input logic [TGT_W-1:0] oa_grp
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
    // R10
    busy_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
    // R11
    tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({mslice_grp, lncf_grp, l3_grp, l3_inst, node_grp,
                           node_inst, dss_grp, dss_inst, oa_grp}));
    // R2
    lncf_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lncf_grp == (mslice_grp << 1));
    // R3
    l3_inst_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l3_grp != '0) |-> (l3_inst == TGT_W'(0) || l3_inst == TGT_W'(2)));
    // R5
    node_inst_chk: assert property (@(posedge clk) disable iff (!rst_n) node_inst <= TGT_W'(1));
    // R8
    oa_range_chk: assert property (@(posedge clk) disable iff (!rst_n) oa_grp <= TGT_W'(1));
endmodule

bind steer_target_sel steer_target_sel_chk #(.TGT_W(TGT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .mslice_grp (mslice_grp),
    .lncf_grp   (lncf_grp),
    .l3_grp     (l3_grp),
    .l3_inst    (l3_inst),
    .node_grp   (node_grp),
    .node_inst  (node_inst),
    .dss_grp    (dss_grp),
    .dss_inst   (dss_inst),
    .oa_grp     (oa_grp)
);

// File: tb/steer_target_sel_tb.sv
// Sweeps the steering selector with default parameters; expected targets are
// computed arithmetically from the requirements.
module steer_target_sel_tb;
    localparam int SLICE_W = 4, NODE_W = 8, DSS_W = 16, L3F_W = 8, DIV_W = 4, TGT_W = 8;
    localparam int LAT = 4; // log2(DSS_W)

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] plat_mode = 2'd1;
    logic l3_legacy = 1'b0;
    logic [SLICE_W-1:0] slice_en = 4'b0010;
    logic l3_bank0_en = 1'b1;
    logic [L3F_W-1:0] l3_fuse = 8'h01;
    logic [NODE_W-1:0] node_en = 8'h04;
    logic [DSS_W-1:0] dss_geom = 16'h0100;
    logic [DSS_W-1:0] dss_comp = 16'h0000;
    logic dpg_valid = 1'b0;
    logic [DIV_W-1:0] dpg_cfg = 4'd0;
    logic media_vid0 = 1'b1;
    logic media_ven0 = 1'b0;
    logic busy, done, cfg_err;
    logic [TGT_W-1:0] mslice_grp, lncf_grp, l3_grp, l3_inst, node_grp, node_inst;
    logic [TGT_W-1:0] dss_grp, dss_inst, oa_grp;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk; // 50 MHz

    steer_target_sel u_dut (.*);

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int low1(int v, int w);
        for (int i = 0; i < w; i++) if (v[i]) return i;
        return 0;
    endfunction

    // Watchdog: an expired run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Pulse start, then measure the edges until done (R10).
    task automatic launch();
        int n = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10", "busy after start", int'(busy), 1);
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk("R10", "latency", n, LAT);
        chk("R10", "busy low with done", int'(busy), 0);
    endtask

    // Compare every output against values derived from the current inputs.
    task automatic verify();
        int s = low1(int'(slice_en), SLICE_W);
        int nd = low1(int'(node_en), NODE_W);
        int d = low1(int'(dss_geom | dss_comp), DSS_W);
        int p;
        int err;
        if (dpg_valid && dpg_cfg != 0) p = int'(dpg_cfg);
        else p = (plat_mode == 2'd0) ? 6 : (plat_mode == 2'd2) ? 8 : 4;
        err = (slice_en == 0 || node_en == 0 || (dss_geom | dss_comp) == 0 ||
               (l3_legacy && l3_fuse == 8'hFF)) ? 1 : 0;
        chk("R2", "mslice_grp", int'(mslice_grp), s);
        chk("R2", "lncf_grp", int'(lncf_grp), s * 2);
        if (l3_legacy) begin
            chk("R4", "l3_grp", int'(l3_grp), 0);
            chk("R4", "l3_inst", int'(l3_inst), low1(int'(~l3_fuse), L3F_W));
        end else begin
            chk("R3", "l3_grp", int'(l3_grp), s);
            chk("R3", "l3_inst", int'(l3_inst), l3_bank0_en ? 0 : 2);
        end
        chk("R5", "node_grp", int'(node_grp), nd / 2);
        chk("R5", "node_inst", int'(node_inst), nd % 2);
        chk("R6", "dss_grp", int'(dss_grp), d / p);
        chk("R6", "dss_inst", int'(dss_inst), d % p);
        chk("R8", "oa_grp", int'(oa_grp), (media_vid0 || media_ven0) ? 0 : 1);
        chk("R9", "cfg_err", int'(cfg_err), err);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "done", int'(done), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "cfg_err", int'(cfg_err), 0);
        chk("R1", "targets", int'(mslice_grp | lncf_grp | l3_grp | l3_inst | node_grp |
                                  node_inst | dss_grp | dss_inst | oa_grp), 0);
        rst_n = 1'b1;

        // R2 R3 R9: every slice mask with both bank-0 states
        for (int sm = 0; sm < 16; sm++) begin
            for (int b = 0; b < 2; b++) begin
                slice_en = 4'(sm);
                l3_bank0_en = b[0];
                launch();
                verify();
            end
        end
        slice_en = 4'b0100;

        // R4 R9: every legacy fuse pattern
        l3_legacy = 1'b1;
        for (int f = 0; f < 256; f++) begin
            l3_fuse = 8'(f);
            launch();
            verify();
        end
        l3_legacy = 1'b0;

        // R5 R9: every node mask
        for (int nm = 0; nm < 256; nm++) begin
            node_en = 8'(nm);
            launch();
            verify();
        end
        node_en = 8'h02;

        // R6: every DSS position against every configured divisor
        dpg_valid = 1'b1;
        for (int i = 0; i < 16; i++) begin
            for (int q = 1; q < 16; q++) begin
                dss_geom = (i % 2 == 0) ? 16'(1 << i) : 16'h8000;
                dss_comp = (i % 2 == 0) ? 16'h8000 : 16'(1 << i);
                dpg_cfg = 4'(q);
                launch();
                verify();
            end
        end

        // R7: platform fallback with no config and with a zero config
        dss_geom = 16'h8000;
        dss_comp = 16'h0000;
        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < 2; v++) begin
                plat_mode = 2'(m);
                dpg_valid = v[0];
                dpg_cfg = 4'd0;
                launch();
                verify();
            end
        end

        // R8: media presence combinations
        for (int k = 0; k < 4; k++) begin
            media_vid0 = k[0];
            media_ven0 = k[1];
            launch();
            verify();
        end

        // R11: second start and input changes during busy are ignored
        slice_en = 4'b1000;
        node_en = 8'h10;
        dss_geom = 16'h0020;
        dpg_valid = 1'b1;
        dpg_cfg = 4'd3;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        slice_en = 4'b0001;
        node_en = 8'h01;
        dss_geom = 16'h0001;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        chk("R11", "mslice_grp held", int'(mslice_grp), 3);
        chk("R11", "node_grp held", int'(node_grp), 2);
        chk("R11", "dss_grp held", int'(dss_grp), 1);
        chk("R11", "dss_inst held", int'(dss_inst), 2);
        begin
            int extra = 0;
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (done) extra++;
            end
            chk("R11", "no second done", extra, 0);
            chk("R11", "mslice_grp stable", int'(mslice_grp), 3);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule